// File: doc/BRIEF.md
# Bridge Transaction Ordering Arbiter

This block sits on one forwarding direction of a two-port bus bridge. It picks which queued item is launched next on the outgoing bus. There are three sources: the head of the posted-write FIFO, a set of delayed-request slots, and a set of delayed-completion slots. Each source offers a valid flag and a sequence tag. The tag is stamped from a shared counter when the item is queued.

The arbiter enforces producer-consumer ordering. A delayed item may launch only once no posted write with an older tag remains. Posted writes are never held back by delayed traffic. When both classes are ready, a fairness flag alternates the grant between them. Delayed items that are eligible may go in any order, so a round-robin pointer spreads grants across the delayed slots.

The grant is combinational. It is valid in any cycle where the launch-ready input is high. Internal state advances only on a cycle where a grant is issued. The opposite direction uses a second instance.

Top module: `ord_arb`

## Requirements
- R1: At most one grant output is high in any cycle, and no grant is given while `launch_rdy` is low.
- R2: When `pw_vld` and `launch_rdy` are both high, some grant is always given. Posted writes are never blocked by ordering.
- R3: Delayed-request slot i is not granted while `pw_vld` is high and the posted head tag is older than that slot's tag.
- R4: Delayed-completion slot i is not granted while `pw_vld` is high and the posted head tag is older than that slot's tag.
- R5: A valid delayed slot is eligible when `pw_vld` is low, or when the posted head tag is not older than the slot's tag. An eligible slot is granted when it is the chosen class and slot.
- R6: When the posted head and at least one delayed slot are both eligible, the grant goes to the class not granted on the most recent grant cycle.
- R7: After reset, the first tie between the two classes goes to the posted write.
- R8: Delayed slots are indexed requests 0..NDR-1, then completions NDR..NDR+NDC-1. The delayed choice is the first eligible index at or after the round-robin pointer, wrapping around. After a delayed grant to index k, the pointer becomes k+1 modulo the slot count. After reset the pointer is 0.
- R9: Tag a is older than tag b when (a - b) modulo 2^TAG_W has its top bit set. Comparisons stay correct across counter wrap, as long as live tags span less than 2^(TAG_W-1).
- R10: In cycles with no grant, which includes every cycle with `launch_rdy` low, both the fairness flag and the round-robin pointer hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch_rdy | input | 1 | Outgoing bus can start a launch this cycle |
| pw_vld | input | 1 | Posted-write FIFO head is valid |
| pw_tag | input | TAG_W | Sequence tag of the posted-write head |
| dr_vld | input | NDR | Delayed-request slot valid flags |
| dr_tag | input | NDR*TAG_W | Delayed-request tags, slot i in bits [i*TAG_W +: TAG_W] |
| dc_vld | input | NDC | Delayed-completion slot valid flags |
| dc_tag | input | NDC*TAG_W | Delayed-completion tags, slot i in bits [i*TAG_W +: TAG_W] |
| gnt_pw | output | 1 | Launch the posted-write head |
| gnt_dr | output | NDR | One-hot launch of a delayed-request slot |
| gnt_dc | output | NDC | One-hot launch of a delayed-completion slot |

## Verification
The bench targets three kinds of corner case.

- **Tag wrap.** Tags placed on either side of the counter wrap check the age test. A plain magnitude compare would let a read overtake an older write, or freeze a delayed slot behind a younger one.
- **Fairness ties.** Back-to-back ties, both right after reset and after stalls with `launch_rdy` low, expose a fairness flag that starts on the wrong class or moves on idle cycles. Either fault would give posted writes two turns in a row, or starve them.
- **Round-robin rotation.** All delayed slots are filled with requests and completions together. This checks that the rotation crosses from the request slots into the completion slots and wraps back to 0. A fixed-priority pick would starve the high indices.

// File: rtl/ord_arb_pkg.sv
package ord_arb_pkg;

   // class chosen by the fairness stage
   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_PW   = 2'd1,
      CLS_DLY  = 2'd2
   } grant_cls_e;

endpackage

// File: rtl/ord_age_filter.sv
// Marks each delayed slot that no older posted write is still blocking.
module ord_age_filter #(
   parameter int TAG_W = 6,
   parameter int N     = 4
) (
   input  logic               pw_vld,
   input  logic [TAG_W-1:0]   pw_tag,
   input  logic [N-1:0]       slot_vld,
   input  logic [N*TAG_W-1:0] slot_tag,
   output logic [N-1:0]       slot_elig
);

   generate
      if (TAG_W < 3) begin : g_bad_tag
         $error("ord_age_filter: TAG_W must be at least 3");
      end
      if (N < 1) begin : g_bad_n
         $error("ord_age_filter: N must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_slot
         logic [TAG_W-1:0] diff;
         logic             pw_is_older;
         // wrap-aware age: posted head is older when the difference is negative
         assign diff        = pw_tag - slot_tag[gi*TAG_W +: TAG_W];
         assign pw_is_older = diff[TAG_W-1];
         assign slot_elig[gi] = slot_vld[gi] & (~pw_vld | ~pw_is_older);
      end
   endgenerate

endmodule

// File: rtl/ord_rr_pick.sv
// Round-robin pick among eligible delayed slots; pointer moves on a taken grant.
module ord_rr_pick #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] pick,
   output logic         any
);

   localparam int IW = (N > 1) ? $clog2(N) : 1;
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   generate
      if (N < 2) begin : g_bad_n
         $error("ord_rr_pick: N must be at least 2");
      end
   endgenerate

   logic [IW-1:0] ptr_q;
   logic [IW-1:0] sel;
   logic          found;

   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = int'(ptr_q) + k;
         if (j >= N) j = j - N;
         if (!found && req[j]) begin
            found = 1'b1;
            sel   = IW'(j);
         end
      end
   end

   always_comb begin
      pick = '0;
      if (found) pick[sel] = 1'b1;
   end

   assign any = found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv && found) begin
         ptr_q <= (sel == LAST) ? '0 : sel + 1'b1;
      end
   end

endmodule

// File: rtl/ord_fair_sel.sv
// Chooses posted vs delayed class; on a tie, alternates with the last grant.
module ord_fair_sel
   import ord_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pw_ready,
   input  logic       dly_ready,
   input  logic       fire,
   output grant_cls_e cls
);

   logic last_pw_q;

   always_comb begin
      if (pw_ready && dly_ready) cls = last_pw_q ? CLS_DLY : CLS_PW;
      else if (pw_ready)         cls = CLS_PW;
      else if (dly_ready)        cls = CLS_DLY;
      else                       cls = CLS_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_pw_q <= 1'b0;
      end else if (fire && cls != CLS_NONE) begin
         last_pw_q <= (cls == CLS_PW);
      end
   end

endmodule

// File: rtl/ord_arb.sv
module ord_arb
   import ord_arb_pkg::*;
#(
   parameter int TAG_W = 6,
   parameter int NDR   = 4,
   parameter int NDC   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch_rdy,
   input  logic                 pw_vld,
   input  logic [TAG_W-1:0]     pw_tag,
   input  logic [NDR-1:0]       dr_vld,
   input  logic [NDR*TAG_W-1:0] dr_tag,
   input  logic [NDC-1:0]       dc_vld,
   input  logic [NDC*TAG_W-1:0] dc_tag,
   output logic                 gnt_pw,
   output logic [NDR-1:0]       gnt_dr,
   output logic [NDC-1:0]       gnt_dc
);

   localparam int ND = NDR + NDC;

   generate
      if (NDR < 1 || NDC < 1) begin : g_bad_slots
         $error("ord_arb: NDR and NDC must be at least 1");
      end
      if (TAG_W < 3) begin : g_bad_tag
         $error("ord_arb: TAG_W must be at least 3");
      end
   endgenerate

   logic [ND-1:0]       d_vld;
   logic [ND*TAG_W-1:0] d_tag;
   logic [ND-1:0]       d_elig;
   logic [ND-1:0]       d_pick;
   logic                d_any;
   grant_cls_e          cls;
   logic                take_dly;

   // requests occupy the low indices, completions follow
   assign d_vld = {dc_vld, dr_vld};
   assign d_tag = {dc_tag, dr_tag};

   ord_age_filter #(.TAG_W(TAG_W), .N(ND)) age_i (
      .pw_vld    (pw_vld),
      .pw_tag    (pw_tag),
      .slot_vld  (d_vld),
      .slot_tag  (d_tag),
      .slot_elig (d_elig)
   );

   ord_fair_sel fair_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pw_ready  (pw_vld),
      .dly_ready (d_any),
      .fire      (launch_rdy),
      .cls       (cls)
   );

   assign take_dly = launch_rdy && (cls == CLS_DLY);

   ord_rr_pick #(.N(ND)) rr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (d_elig),
      .adv   (take_dly),
      .pick  (d_pick),
      .any   (d_any)
   );

   assign gnt_pw = launch_rdy && (cls == CLS_PW);
   assign gnt_dr = take_dly ? d_pick[NDR-1:0]  : '0;
   assign gnt_dc = take_dly ? d_pick[ND-1:NDR] : '0;

endmodule

// File: rtl/ord_arb_chk.sv
module ord_arb_chk #(
   parameter int TAG_W = 6,
   parameter int NDR   = 4,
   parameter int NDC   = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 launch_rdy,
   input logic                 pw_vld,
   input logic [TAG_W-1:0]     pw_tag,
   input logic [NDR-1:0]       dr_vld,
   input logic [NDR*TAG_W-1:0] dr_tag,
   input logic [NDC-1:0]       dc_vld,
   input logic [NDC*TAG_W-1:0] dc_tag,
   input logic                 gnt_pw,
   input logic [NDR-1:0]       gnt_dr,
   input logic [NDC-1:0]       gnt_dc
);

   function automatic logic older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
      logic [TAG_W-1:0] d;
      d = a - b;
      return d[TAG_W-1];
   endfunction

   logic [NDR-1:0] dr_ok;
   logic [NDC-1:0] dc_ok;
   logic           prev_pw_q;

   always_comb begin
      for (int i = 0; i < NDR; i++)
         dr_ok[i] = dr_vld[i] && !(pw_vld && older(pw_tag, dr_tag[i*TAG_W +: TAG_W]));
      for (int i = 0; i < NDC; i++)
         dc_ok[i] = dc_vld[i] && !(pw_vld && older(pw_tag, dc_tag[i*TAG_W +: TAG_W]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prev_pw_q <= 1'b0;
      else if (launch_rdy) prev_pw_q <= gnt_pw;
   end

   assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_pw, gnt_dr, gnt_dc}));

   assert_idle_no_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !launch_rdy |-> ({gnt_pw, gnt_dr, gnt_dc} == '0));

   assert_posted_served_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_rdy && pw_vld) |-> (gnt_pw || (|gnt_dr) || (|gnt_dc)));

   genvar gi;
   generate
      for (gi = 0; gi < NDR; gi++) begin : g_dr
         assert_req_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_dr[gi] |-> (dr_vld[gi] && !(pw_vld && older(pw_tag, dr_tag[gi*TAG_W +: TAG_W]))));
      end
      for (gi = 0; gi < NDC; gi++) begin : g_dc
         assert_cpl_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_dc[gi] |-> (dc_vld[gi] && !(pw_vld && older(pw_tag, dc_tag[gi*TAG_W +: TAG_W]))));
      end
   endgenerate

   // two posted grants in a row are legal only if nothing delayed was ready
   assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_pw && prev_pw_q) |-> ((dr_ok == '0) && (dc_ok == '0)));

endmodule

bind ord_arb ord_arb_chk #(.TAG_W(TAG_W), .NDR(NDR), .NDC(NDC)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .launch_rdy (launch_rdy),
   .pw_vld     (pw_vld),
   .pw_tag     (pw_tag),
   .dr_vld     (dr_vld),
   .dr_tag     (dr_tag),
   .dc_vld     (dc_vld),
   .dc_tag     (dc_tag),
   .gnt_pw     (gnt_pw),
   .gnt_dr     (gnt_dr),
   .gnt_dc     (gnt_dc)
);

// File: tb/ord_arb_tb_top.sv
`timescale 1ns/1ps
module ord_arb_tb_top;

   localparam int TAG_W = 6;
   localparam int NDR   = 4;
   localparam int NDC   = 4;
   localparam int ND    = NDR + NDC;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 launch_rdy = 1'b0;
   logic                 pw_vld = 1'b0;
   logic [TAG_W-1:0]     pw_tag = '0;
   logic [NDR-1:0]       dr_vld = '0;
   logic [NDR*TAG_W-1:0] dr_tag = '0;
   logic [NDC-1:0]       dc_vld = '0;
   logic [NDC*TAG_W-1:0] dc_tag = '0;
   logic                 gnt_pw;
   logic [NDR-1:0]       gnt_dr;
   logic [NDC-1:0]       gnt_dc;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // bench model state
   bit m_last_pw;
   int m_ptr;

   always #2.5 clk = ~clk;

   ord_arb #(.TAG_W(TAG_W), .NDR(NDR), .NDC(NDC)) dut_i (
      .clk(clk), .rst_n(rst_n), .launch_rdy(launch_rdy),
      .pw_vld(pw_vld), .pw_tag(pw_tag),
      .dr_vld(dr_vld), .dr_tag(dr_tag),
      .dc_vld(dc_vld), .dc_tag(dc_tag),
      .gnt_pw(gnt_pw), .gnt_dr(gnt_dr), .gnt_dc(gnt_dc)
   );

   // R9: wrap-aware age
   function automatic bit m_older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
      logic [TAG_W-1:0] d;
      d = a - b;
      return d[TAG_W-1];
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // compare against the model for the current inputs, then advance the model
   task automatic step(input string rq);
      bit          e [ND];
      bit          any, tp, td;
      int          sel;
      bit          x_pw;
      logic [ND-1:0] x_d;
      logic [ND-1:0] a_d;
      #1;
      any = 0;
      for (int i = 0; i < ND; i++) begin
         bit v;
         logic [TAG_W-1:0] t;
         if (i < NDR) begin v = dr_vld[i]; t = dr_tag[i*TAG_W +: TAG_W]; end
         else begin v = dc_vld[i-NDR]; t = dc_tag[(i-NDR)*TAG_W +: TAG_W]; end
         e[i] = v && (!pw_vld || !m_older(pw_tag, t));
         any  = any | e[i];
      end
      tp  = pw_vld && (!any || !m_last_pw);
      td  = any && (!pw_vld || m_last_pw);
      sel = 0;
      for (int k = ND - 1; k >= 0; k--) begin
         int j;
         j = (m_ptr + k) % ND;
         if (e[j]) sel = j;
      end
      x_pw = launch_rdy && tp;
      x_d  = '0;
      if (launch_rdy && td) x_d[sel] = 1'b1;
      a_d = {gnt_dc, gnt_dr};
      checks++;
      if (gnt_pw !== x_pw || a_d !== x_d) begin
         errors++;
         $display("FAIL %s: actual pw=%0b dly=%b expected pw=%0b dly=%b",
                  rq, gnt_pw, a_d, x_pw, x_d);
      end
      if (launch_rdy && (tp || td)) begin
         m_last_pw = tp;
         if (td) m_ptr = (sel + 1) % ND;
      end
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; launch_rdy = 0; pw_vld = 0; dr_vld = '0; dc_vld = '0;
      m_last_pw = 0; m_ptr = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_dr(input int i, input int t);
      dr_vld[i] = 1'b1;
      dr_tag[i*TAG_W +: TAG_W] = TAG_W'(t);
   endtask

   task automatic set_dc(input int i, input int t);
      dc_vld[i] = 1'b1;
      dc_tag[i*TAG_W +: TAG_W] = TAG_W'(t);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      do_reset();

      // reset state: nothing valid, no grant (R1, R7)
      launch_rdy = 1; step("R1 reset idle");
      // stalled bus gives no grant (R1, R10)
      launch_rdy = 0; pw_vld = 1; pw_tag = 6'd10; step("R1 stalled");
      launch_rdy = 1; step("R2 posted alone");

      // younger delayed request waits behind older posted (R3)
      set_dr(0, 12); step("R3 blocked 1"); step("R3 blocked 2");
      dr_vld = '0;
      // younger completion waits too (R4)
      set_dc(1, 12); step("R4 blocked 1"); step("R4 blocked 2");
      dc_vld = '0;

      // tie straight after reset goes posted, then alternates (R7, R6)
      do_reset();
      launch_rdy = 1; pw_vld = 1; pw_tag = 6'd10; set_dr(2, 5);
      step("R7 first tie posted"); step("R6 alternate delayed"); step("R6 alternate posted");
      // idle cycles keep the fairness flag (R10)
      launch_rdy = 0; step("R10 hold 1"); step("R10 hold 2");
      launch_rdy = 1; step("R10 resume");
      dr_vld = '0;

      // wrap: 62 older than 1 so delayed slot blocked (R9)
      pw_tag = 6'd62; set_dr(1, 1); step("R9 wrap blocked 1"); step("R9 wrap blocked 2");
      // wrap: 1 younger than 62 so delayed slot eligible (R9)
      pw_tag = 6'd1; set_dr(1, 62); step("R9 wrap eligible 1"); step("R9 wrap eligible 2");
      dr_vld = '0; pw_vld = 0;

      // no posted: delayed eligible at any tag (R5)
      set_dr(3, 40); set_dc(0, 9); step("R5 no posted 1"); step("R5 no posted 2");

      // all slots full: rotation across requests and completions (R8)
      do_reset();
      launch_rdy = 1;
      for (int i = 0; i < NDR; i++) set_dr(i, 20 + i);
      for (int i = 0; i < NDC; i++) set_dc(i, 30 + i);
      for (int n = 0; n < ND + 3; n++) step("R8 rotation");

      // constrained random mix (R1 R2 R3 R4 R5 R6 R8 R10)
      for (int n = 0; n < 3000; n++) begin
         int base;
         base       = int'($urandom_range(0, 63));
         launch_rdy = ($urandom_range(0, 9) < 8);
         pw_vld     = ($urandom_range(0, 2) != 0);
         pw_tag     = TAG_W'(base + int'($urandom_range(0, 23)));
         for (int i = 0; i < NDR; i++) begin
            dr_vld[i] = ($urandom_range(0, 2) == 0);
            dr_tag[i*TAG_W +: TAG_W] = TAG_W'(base + int'($urandom_range(0, 23)));
         end
         for (int i = 0; i < NDC; i++) begin
            dc_vld[i] = ($urandom_range(0, 2) == 0);
            dc_tag[i*TAG_W +: TAG_W] = TAG_W'(base + int'($urandom_range(0, 23)));
         end
         step("R1 R2 R3 R4 R5 R6 R8 R10 random");
      end

      done = 1;
      summary();
      $finish;
   end

endmodule